// File: doc/BRIEF.md
# Special-Purpose Register Write Unit

This block holds a file of special-purpose registers for a processor core. A write port takes a 16-bit register number and a 32-bit value; a combinational read port returns the stored contents of any register. The register number is folded to the implemented register count before it indexes the file, so numbers above that count alias onto lower registers.

Most writes are not plain stores. Some registers self-clear or self-set after a write. The status register always stores with a fixed bit set, and its flag bit drives a condition flag. Translation-table entries are stored with the offset bits below the page size cleared and their reserved fields cleared. One 32-entry window mirrors writes into the general-purpose register file. Other writes raise single-cycle request strobes toward the data cache, the fetch unit, the tick timer and the power controller. Those units are not part of this block. It only issues the requests, registered one cycle after the write, and the stored value can be read back in that same cycle.

Top module: `spr_write_unit`

## Requirements
- R1: The register number is reduced modulo 2^IDX_W (default 2048) before use. A write to 0x0805 is stored in, and read back from, register 0x0005, and a read of 0x1005 returns the same value.
- R2: A write to the status register 0x0011 sets `cond_flag` to bit 9 of the value in the next cycle. The register then reads back as the value with bit 15 forced to one.
- R3: A nonzero write to the probe register 0x0100 raises `cache_req` with `cache_inval`=0 and `cache_addr` equal to the value. The register always reads back zero. A zero write raises no request.
- R4: A write to the flush register 0x0101 that is not 0xFFFFFFFF raises `cache_req` with `cache_inval`=1 at that address. The register always reads back 0xFFFFFFFF. An all-ones write raises no request.
- R5: A nonzero write to the invalidate register 0x0102 raises an invalidate request at that address, and a zero write raises none. This register and the write-back and lock registers 0x0103 and 0x0104 always read back zero, and the last two raise no request.
- R6: A write to the next-PC register 0x0010 raises `redir_valid`, which also cancels any pending delay-slot branch, with `redir_pc` equal to the value and `redir_next_pc` equal to the value plus 4. The value is stored as written.
- R7: Registers 0x0200–0x027F (data) and 0x0300–0x037F (instruction) are match entries. Each stores the value with bits below log2(PAGE_BYTES) (default 13) cleared, except bits 7:0 (valid, level, context id, replacement), which are kept.
- R8: Registers 0x0280–0x02FF are data translate entries and keep bits 9:0 below the page boundary. Registers 0x0380–0x03FF are instruction translate entries and keep only bits 7:0. Both clear the other bits below the page boundary.
- R9: A write to 0x0400–0x041F raises `gpr_we` with `gpr_idx` equal to the register number minus 0x0400 and `gpr_data` equal to the value. It is also stored. A write to 0x0420 raises no `gpr_we`.
- R10: A write to the power register 0x0050 raises `suspend_req` exactly when bit 5 is set. Bits 4:0 cause no request.
- R11: A write to the timer count register 0x0060 or the timer mode register 0x0061 raises `timer_we` with `timer_data` equal to the value. `timer_sel_mode` is 0 for the count register and 1 for the mode register.
- R12: Every strobe is high for exactly the one cycle after the write. A cycle without a write raises no strobe.
- R13: A register with no special handling stores the value exactly as written.
- R14: After reset all registers read zero, and `cond_flag` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Register number to write |
| wr_data | input | 32 | Value to write |
| rd_addr | input | 16 | Register number to read |
| rd_data | output | 32 | Stored contents of rd_addr (combinational) |
| cond_flag | output | 1 | Condition flag from the status register |
| cache_req | output | 1 | Cache block request pulse |
| cache_inval | output | 1 | 1 = invalidate, 0 = 4-byte probe |
| cache_addr | output | 32 | Address of the cache request |
| redir_valid | output | 1 | Fetch redirect pulse, also cancels a pending delay slot |
| redir_pc | output | 32 | New fetch address |
| redir_next_pc | output | 32 | Following fetch address |
| gpr_we | output | 1 | General-purpose register write pulse |
| gpr_idx | output | 5 | General-purpose register index |
| gpr_data | output | 32 | General-purpose register write value |
| suspend_req | output | 1 | Suspend request pulse |
| timer_we | output | 1 | Timer update pulse |
| timer_sel_mode | output | 1 | 0 = count register, 1 = mode register |
| timer_data | output | 32 | Value for the timer |

## Verification
The bench walks every register number of both translation windows. A wrong match/translate split at the 0x80 boundary, or the data masks used on instruction entries, would store the wrong kept bits. It covers all 32 alias addresses and the first one past the window, where an off-by-one range would raise a spurious register write. The self-clearing registers get both their triggering value and their non-triggering value (zero, or all-ones for the flush register), so an inverted trigger shows up as a request that should not be there. Each power-register bit is set alone, so a design that suspends on any nonzero value fails. Folded and aliased reads catch a design that indexes with too many address bits.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    // Register numbers (after folding)
    localparam logic [15:0] ADR_NEXT_PC  = 16'h0010;
    localparam logic [15:0] ADR_STATUS   = 16'h0011;
    localparam logic [15:0] ADR_POWER    = 16'h0050;
    localparam logic [15:0] ADR_TMR_CNT  = 16'h0060;
    localparam logic [15:0] ADR_TMR_MODE = 16'h0061;
    localparam logic [15:0] ADR_CB_PROBE = 16'h0100;
    localparam logic [15:0] ADR_CB_FLUSH = 16'h0101;
    localparam logic [15:0] ADR_CB_INVAL = 16'h0102;
    localparam logic [15:0] ADR_CB_WBACK = 16'h0103;
    localparam logic [15:0] ADR_CB_LOCK  = 16'h0104;
    localparam logic [7:0]  PAGE_DTLB    = 8'h02;
    localparam logic [7:0]  PAGE_ITLB    = 8'h03;
    localparam logic [10:0] GPR_WINDOW   = 11'h020;   // 0x0400 >> 5

    // Bit positions
    localparam int STAT_FLAG_BIT  = 9;
    localparam int STAT_FIXED_BIT = 15;
    localparam int PWR_SUSP_BIT   = 5;

    // Fields kept below the page boundary
    localparam logic [31:0] KEEP_MATCH  = 32'h0000_00FF;
    localparam logic [31:0] KEEP_DXLAT  = 32'h0000_03FF;
    localparam logic [31:0] KEEP_IXLAT  = 32'h0000_00FF;

    typedef enum logic [3:0] {
        K_PLAIN, K_STATUS, K_NEXT_PC, K_CB_PROBE, K_CB_FLUSH, K_CB_INVAL,
        K_CB_ZERO, K_DTLB_MATCH, K_DTLB_XLAT, K_ITLB_MATCH, K_ITLB_XLAT,
        K_GPR_ALIAS, K_POWER, K_TMR_CNT, K_TMR_MODE
    } spr_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] store_val;
        logic              flag_we;
        logic              flag_val;
        logic              cache_req;
        logic              cache_inval;
        logic              redirect;
        logic              gpr_we;
        logic [4:0]        gpr_idx;
        logic              suspend;
        logic              timer_we;
        logic              timer_mode;
    } spr_effect_t;

    function automatic logic [DATA_W-1:0] page_keep(
        input logic [DATA_W-1:0] value,
        input logic [DATA_W-1:0] low_mask,
        input logic [DATA_W-1:0] keep
    );
        return (value & ~low_mask) | (value & keep);
    endfunction

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic [IDX_W-1:0] idx,
    output spr_kind_e        kind
);
    logic [15:0] a16;
    assign a16 = 16'(idx);

    always_comb begin
        kind = K_PLAIN;
        if (a16 == ADR_STATUS)                               kind = K_STATUS;
        else if (a16 == ADR_NEXT_PC)                         kind = K_NEXT_PC;
        else if (a16 == ADR_CB_PROBE)                        kind = K_CB_PROBE;
        else if (a16 == ADR_CB_FLUSH)                        kind = K_CB_FLUSH;
        else if (a16 == ADR_CB_INVAL)                        kind = K_CB_INVAL;
        else if (a16 == ADR_CB_WBACK || a16 == ADR_CB_LOCK)  kind = K_CB_ZERO;
        else if (a16 == ADR_POWER)                           kind = K_POWER;
        else if (a16 == ADR_TMR_CNT)                         kind = K_TMR_CNT;
        else if (a16 == ADR_TMR_MODE)                        kind = K_TMR_MODE;
        else if (a16[15:8] == PAGE_DTLB)
            kind = a16[7] ? K_DTLB_XLAT : K_DTLB_MATCH;
        else if (a16[15:8] == PAGE_ITLB)
            kind = a16[7] ? K_ITLB_XLAT : K_ITLB_MATCH;
        else if (a16[15:5] == GPR_WINDOW)                    kind = K_GPR_ALIAS;
    end
endmodule

// File: rtl/spr_effect.sv
module spr_effect
    import spr_pkg::*;
#(
    parameter int PAGE_SHIFT = 13
) (
    input  spr_kind_e          kind,
    input  logic [4:0]         low5,
    input  logic [DATA_W-1:0]  value,
    output spr_effect_t        eff
);
    localparam logic [DATA_W-1:0] LOW_MASK = (DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1);

    logic nonzero, all_ones;
    assign nonzero  = |value;
    assign all_ones = &value;

    always_comb begin
        eff           = '0;
        eff.store_val = value;
        unique case (kind)
            K_STATUS: begin
                eff.store_val = value | (DATA_W'(1) << STAT_FIXED_BIT);
                eff.flag_we   = 1'b1;
                eff.flag_val  = value[STAT_FLAG_BIT];
            end
            K_NEXT_PC:  eff.redirect = 1'b1;
            K_CB_PROBE: begin
                eff.store_val = '0;
                eff.cache_req = nonzero;
            end
            K_CB_FLUSH: begin
                eff.store_val   = '1;
                eff.cache_req   = !all_ones;
                eff.cache_inval = 1'b1;
            end
            K_CB_INVAL: begin
                eff.store_val   = '0;
                eff.cache_req   = nonzero;
                eff.cache_inval = 1'b1;
            end
            K_CB_ZERO:    eff.store_val = '0;
            K_DTLB_MATCH,
            K_ITLB_MATCH: eff.store_val = page_keep(value, LOW_MASK, KEEP_MATCH);
            K_DTLB_XLAT:  eff.store_val = page_keep(value, LOW_MASK, KEEP_DXLAT);
            K_ITLB_XLAT:  eff.store_val = page_keep(value, LOW_MASK, KEEP_IXLAT);
            K_GPR_ALIAS: begin
                eff.gpr_we  = 1'b1;
                eff.gpr_idx = low5;
            end
            K_POWER:    eff.suspend = value[PWR_SUSP_BIT];
            K_TMR_CNT:  eff.timer_we = 1'b1;
            K_TMR_MODE: begin
                eff.timer_we   = 1'b1;
                eff.timer_mode = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spr_regfile.sv
module spr_regfile
    import spr_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int NUM_REGS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spr_write_unit.sv
module spr_write_unit
    import spr_pkg::*;
#(
    parameter int IDX_W      = 11,
    parameter int PAGE_BYTES = 8192
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [15:0] rd_addr,
    output logic [31:0] rd_data,
    output logic        cond_flag,
    output logic        cache_req,
    output logic        cache_inval,
    output logic [31:0] cache_addr,
    output logic        redir_valid,
    output logic [31:0] redir_pc,
    output logic [31:0] redir_next_pc,
    output logic        gpr_we,
    output logic [4:0]  gpr_idx,
    output logic [31:0] gpr_data,
    output logic        suspend_req,
    output logic        timer_we,
    output logic        timer_sel_mode,
    output logic [31:0] timer_data
);
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

    logic [IDX_W-1:0] w_idx, r_idx;
    logic             unused_addr_hi;
    spr_kind_e        kind;
    spr_effect_t      eff;

    // Fold register numbers onto the implemented count (power of two)
    assign w_idx          = wr_addr[IDX_W-1:0];
    assign r_idx          = rd_addr[IDX_W-1:0];
    assign unused_addr_hi = ^{wr_addr[ADDR_W-1:IDX_W], rd_addr[ADDR_W-1:IDX_W]};

    spr_decode #(.IDX_W(IDX_W)) dec_i (
        .idx  (w_idx),
        .kind (kind)
    );

    spr_effect #(.PAGE_SHIFT(PAGE_SHIFT)) eff_i (
        .kind  (kind),
        .low5  (w_idx[4:0]),
        .value (wr_data),
        .eff   (eff)
    );

    spr_regfile #(.IDX_W(IDX_W)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (w_idx),
        .wdata (eff.store_val),
        .raddr (r_idx),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_flag      <= 1'b0;
            cache_req      <= 1'b0;
            cache_inval    <= 1'b0;
            cache_addr     <= '0;
            redir_valid    <= 1'b0;
            redir_pc       <= '0;
            redir_next_pc  <= '0;
            gpr_we         <= 1'b0;
            gpr_idx        <= '0;
            gpr_data       <= '0;
            suspend_req    <= 1'b0;
            timer_we       <= 1'b0;
            timer_sel_mode <= 1'b0;
            timer_data     <= '0;
        end else begin
            if (wr_en && eff.flag_we) cond_flag <= eff.flag_val;
            cache_req   <= wr_en && eff.cache_req;
            redir_valid <= wr_en && eff.redirect;
            gpr_we      <= wr_en && eff.gpr_we;
            suspend_req <= wr_en && eff.suspend;
            timer_we    <= wr_en && eff.timer_we;
            if (wr_en) begin
                cache_inval    <= eff.cache_inval;
                cache_addr     <= wr_data;
                redir_pc       <= wr_data;
                redir_next_pc  <= wr_data + 32'd4;
                gpr_idx        <= eff.gpr_idx;
                gpr_data       <= wr_data;
                timer_sel_mode <= eff.timer_mode;
                timer_data     <= wr_data;
            end
        end
    end
endmodule

// File: rtl/spr_write_unit_chk.sv
module spr_write_unit_chk
    import spr_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        cond_flag,
    input logic        cache_req,
    input logic        cache_inval,
    input logic [31:0] cache_addr,
    input logic        redir_valid,
    input logic [31:0] redir_pc,
    input logic [31:0] redir_next_pc,
    input logic        gpr_we,
    input logic [31:0] gpr_data,
    input logic        suspend_req,
    input logic        timer_we
);
    logic status_wr;
    assign status_wr = wr_en && (wr_addr[IDX_W-1:0] == ADR_STATUS[IDX_W-1:0]);

    p_flag_follows_r2: assert property (@(posedge clk) disable iff (rst)
        status_wr |=> cond_flag == $past(wr_data[STAT_FLAG_BIT]));

    p_probe_addr_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (cache_req && !cache_inval) |-> cache_addr != 32'd0);

    p_flush_addr_r4: assert property (@(posedge clk) disable iff (rst)
        cache_req |-> cache_addr == $past(wr_data));

    p_next_pc_plus4_r6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> redir_next_pc == redir_pc + 32'd4);

    p_redir_value_r6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> redir_pc == $past(wr_data));

    p_gpr_value_r9: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> gpr_data == $past(wr_data));

    p_suspend_bit_r10: assert property (@(posedge clk) disable iff (rst)
        suspend_req |-> $past(wr_data[PWR_SUSP_BIT]));

    p_no_write_no_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> !(cache_req || redir_valid || gpr_we || suspend_req || timer_we));

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        $countones({cache_req, redir_valid, gpr_we, suspend_req, timer_we}) <= 1);
endmodule

bind spr_write_unit spr_write_unit_chk #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cond_flag   (cond_flag),
    .cache_req   (cache_req),
    .cache_inval (cache_inval),
    .cache_addr  (cache_addr),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .redir_next_pc (redir_next_pc),
    .gpr_we      (gpr_we),
    .gpr_data    (gpr_data),
    .suspend_req (suspend_req),
    .timer_we    (timer_we)
);

// File: tb/spr_write_unit_tb_top.sv
module spr_write_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PAGE_LOW = 32'h0000_1FFF;   // 8 KiB pages

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        cond_flag, cache_req, cache_inval, redir_valid, gpr_we;
    logic        suspend_req, timer_we, timer_sel_mode;
    logic [31:0] cache_addr, redir_pc, redir_next_pc, gpr_data, timer_data;
    logic [4:0]  gpr_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_write_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cond_flag(cond_flag),
        .cache_req(cache_req), .cache_inval(cache_inval), .cache_addr(cache_addr),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_next_pc(redir_next_pc),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .suspend_req(suspend_req), .timer_we(timer_we),
        .timer_sel_mode(timer_sel_mode), .timer_data(timer_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write lands on the next posedge; strobes are visible on return
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [4:0] strobes();
        return {cache_req, redir_valid, gpr_we, suspend_req, timer_we};
    endfunction

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R14: reset state
        chk("R14 strobes", 32'(strobes()), 32'h0);
        chk("R14 flag", 32'(cond_flag), 32'h0);
        rd(16'h0011, v); chk("R14 status", v, 32'h0);
        rd(16'h0101, v); chk("R14 flush reg", v, 32'h0);

        // R13: plain store; R1: folding
        wr(16'h0005, 32'hDEAD_BEEF);
        rd(16'h0005, v); chk("R13 plain", v, 32'hDEAD_BEEF);
        wr(16'h0805, 32'h1357_9BDF);
        rd(16'h0005, v); chk("R1 fold write", v, 32'h1357_9BDF);
        rd(16'h1005, v); chk("R1 fold read", v, 32'h1357_9BDF);

        // R2: status register
        wr(16'h0011, 32'h0000_0200);
        chk("R2 flag set", 32'(cond_flag), 32'h1);
        rd(16'h0011, v); chk("R2 fixed bit", v, 32'h0000_8200);
        wr(16'h0811, 32'hFFFF_7DFF);
        chk("R2 flag clear", 32'(cond_flag), 32'h0);
        rd(16'h0011, v); chk("R2 fixed bit folded", v, 32'hFFFF_FDFF);

        // R3: probe
        wr(16'h0100, 32'h1234_5670);
        chk("R3 req", {cache_req, cache_inval}, 2'b10);
        chk("R3 addr", cache_addr, 32'h1234_5670);
        rd(16'h0100, v); chk("R3 readback", v, 32'h0);
        wr(16'h0100, 32'h0);
        chk("R3 zero no req", 32'(cache_req), 32'h0);

        // R4: flush
        wr(16'h0101, 32'h0000_4440);
        chk("R4 req", {cache_req, cache_inval}, 2'b11);
        chk("R4 addr", cache_addr, 32'h0000_4440);
        rd(16'h0101, v); chk("R4 readback", v, 32'hFFFF_FFFF);
        wr(16'h0101, 32'hFFFF_FFFF);
        chk("R4 ones no req", 32'(cache_req), 32'h0);
        rd(16'h0101, v); chk("R4 readback ones", v, 32'hFFFF_FFFF);

        // R5: invalidate, write-back, lock
        wr(16'h0102, 32'h0000_8000);
        chk("R5 inval req", {cache_req, cache_inval}, 2'b11);
        chk("R5 inval addr", cache_addr, 32'h0000_8000);
        rd(16'h0102, v); chk("R5 inval readback", v, 32'h0);
        wr(16'h0102, 32'h0);
        chk("R5 zero no req", 32'(cache_req), 32'h0);
        for (int k = 0; k < 2; k++) begin
            wr(16'h0103 + 16'(k), 32'hCAFE_0001);
            chk("R5 wb/lock no req", 32'(strobes()), 32'h0);
            rd(16'h0103 + 16'(k), v); chk("R5 wb/lock readback", v, 32'h0);
        end

        // R6: next PC
        wr(16'h0010, 32'h0000_2000);
        chk("R6 redirect", 32'(redir_valid), 32'h1);
        chk("R6 pc", redir_pc, 32'h0000_2000);
        chk("R6 next", redir_next_pc, 32'h0000_2004);
        rd(16'h0010, v); chk("R6 stored", v, 32'h0000_2000);
        // R12: one cycle only
        @(negedge clk);
        chk("R12 pulse ends", 32'(strobes()), 32'h0);

        // R7 / R8: translation windows, every entry
        for (int w = 0; w < 2; w++) begin
            for (int lb = 0; lb < 256; lb++) begin
                logic [7:0]  b;
                logic [31:0] d, keep;
                logic [15:0] a;
                b = 8'(lb);
                d = {b, ~b, b ^ 8'h5A, ~b ^ 8'h3C};
                a = (w == 0) ? {8'h02, b} : {8'h03, b};
                if (lb < 128)     keep = 32'h0000_00FF;
                else if (w == 0)  keep = 32'h0000_03FF;
                else              keep = 32'h0000_00FF;
                wr(a, d);
                rd(a, v);
                chk(lb < 128 ? "R7 match mask" : "R8 translate mask", v, (d & ~PAGE_LOW) | (d & keep));
            end
        end

        // R9: general-purpose alias window
        for (int g = 0; g < 32; g++) begin
            logic [31:0] d;
            d = 32'h0F00_0000 + 32'(g) * 32'h0001_0101;
            wr(16'h0400 + 16'(g), d);
            chk("R9 gpr we", 32'(gpr_we), 32'h1);
            chk("R9 gpr idx", 32'(gpr_idx), 32'(g));
            chk("R9 gpr data", gpr_data, d);
            rd(16'h0400 + 16'(g), v); chk("R9 stored", v, d);
        end
        wr(16'h0420, 32'h1111_2222);
        chk("R9 outside window", 32'(gpr_we), 32'h0);

        // R10: power register, one bit at a time
        for (int bt = 0; bt < 8; bt++) begin
            wr(16'h0050, 32'h1 << bt);
            chk("R10 suspend", 32'(suspend_req), (bt == 5) ? 32'h1 : 32'h0);
        end

        // R11: timer registers
        wr(16'h0060, 32'h0000_ABCD);
        chk("R11 count", {timer_we, timer_sel_mode}, 2'b10);
        chk("R11 count data", timer_data, 32'h0000_ABCD);
        wr(16'h0061, 32'h6000_0010);
        chk("R11 mode", {timer_we, timer_sel_mode}, 2'b11);
        chk("R11 mode data", timer_data, 32'h6000_0010);

        // R12: no write, no strobe; back-to-back writes each pulse once
        @(negedge clk);
        chk("R12 idle", 32'(strobes()), 32'h0);
        wr(16'h0010, 32'h100);
        wr(16'h0060, 32'h7);
        chk("R12 back-to-back", 32'(strobes()), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule